// File: doc/BRIEF.md
# Edge-Capturing Interrupt Controller with Message Dispatch

This controller watches eleven level-sensitive interrupt lines. Each clock it copies the lines into a live-level register. A line that goes from low to high sets a sticky pending bit. If that line is unmasked, it also queues one outbound message. Software configures and inspects the block through a small synchronous register port addressed by byte offset. A read returns its data one cycle after the request.

A message is one 32-bit write. Its target address and its data both come from one of two message registers. The address is the register value with its five low bits cleared, and the data is those five low bits. A per-source class bit chooses the register. The same class bit splits the requests into two read-only views: one for class 0 and one for class 1.

The outbound side is a valid/ready stream. A message is transferred in a cycle where `msg_valid` and `msg_ready` are both high. While `msg_ready` is low, `msg_valid`, `msg_addr` and `msg_data` hold steady. Queued messages wait behind the one on offer and are not lost. Lines 0 to 5 are the PCI INTA to INTF lines, 6 is an external bus interrupt, 7 a bus error, 8 PS2, 9 unused and 10 a serial port.

Top module: `irq_msg_ctrl`

## Requirements
- R1: After reset, every register reads zero and `msg_valid` is low.
- R2: The level register at offset 0x028 shows the source levels sampled at the previous clock edge. Writes to it are ignored.
- R3: The pending register at 0x01C sets bit i only when source i is high and level bit i was low. A source that stays high sets nothing further.
- R4: A read of 0x01C returns the pending value and clears it. A write to 0x01C clears it whatever the data. A rise in the same cycle as the clear stays set.
- R5: The view at 0x00C reads level AND mask AND NOT class. The view at 0x014 reads level AND mask AND class. Writes to either are ignored.
- R6: Message register 0 (0x004) and message register 1 (0x010) are 32-bit read/write. The mask (0x018) and class (0x024) registers keep bits 10:0, and their upper bits read zero.
- R7: A rise of source i with mask bit i set produces exactly one message. With mask bit i clear, the rise produces no message, but pending bit i is still set.
- R8: A message uses message register 1 if class bit i is 1, and message register 0 otherwise. `msg_addr` is that value with bits 4:0 zero. `msg_data` is bits 4:0 of that value, zero-extended.
- R9: Sources that rise in the same cycle send their messages in ascending source order.
- R10: While `msg_valid` is high and `msg_ready` is low, `msg_valid`, `msg_addr` and `msg_data` hold. One handshake removes exactly one message.
- R11: `reg_rdata` carries read data the cycle after `reg_re`. Offsets not listed here read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_lvl | input | 11 | Interrupt source levels |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 12 | Byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after reg_re |
| msg_valid | output | 1 | Outbound message offered |
| msg_ready | input | 1 | Receiver accepts message |
| msg_addr | output | 32 | Message target address |
| msg_data | output | 32 | Message payload |

## Verification
The hardest state to reach is several messages from different classes waiting in the queue behind a stalled output. The bench holds `msg_ready` low and raises three unmasked sources in one cycle, with only the highest of them in class 1. Draining them one handshake at a time then shows whether the order is ascending. A second hard case is a read of the pending register in the same cycle as a new rise. The bench reaches it by driving the read strobe and the rising source on the same clock edge.

// File: rtl/irq_msg_pkg.sv
package irq_msg_pkg;
  localparam int NSRC = 11;
  localparam int DW   = 32;
  localparam int AW   = 12;
  localparam int MLSB = 5;
  localparam logic [AW-1:0] OFS_MSG0 = 12'h004;
  localparam logic [AW-1:0] OFS_REQ0 = 12'h00C;
  localparam logic [AW-1:0] OFS_MSG1 = 12'h010;
  localparam logic [AW-1:0] OFS_REQ1 = 12'h014;
  localparam logic [AW-1:0] OFS_MASK = 12'h018;
  localparam logic [AW-1:0] OFS_PEND = 12'h01C;
  localparam logic [AW-1:0] OFS_CLS  = 12'h024;
  localparam logic [AW-1:0] OFS_LVL  = 12'h028;
endpackage

// File: rtl/irq_capture.sv
module irq_capture #(
  parameter int NSRC = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  output logic [NSRC-1:0] lvl_o,
  output logic [NSRC-1:0] rise_o
);
  logic [NSRC-1:0] lvl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) lvl_q <= '0;
    else        lvl_q <= src_i;
  end

  // a rise is a high input whose previous sample was low
  assign rise_o = src_i & ~lvl_q;
  assign lvl_o  = lvl_q;
endmodule

// File: rtl/irq_regfile.sv
module irq_regfile
  import irq_msg_pkg::*;
#(
  parameter int NSRC = 11,
  parameter int DW   = 32,
  parameter int AW   = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we_i,
  input  logic            re_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   rdata_o,
  input  logic [NSRC-1:0] lvl_i,
  input  logic [NSRC-1:0] rise_i,
  output logic [NSRC-1:0] mask_o,
  output logic [NSRC-1:0] class_o,
  output logic [DW-1:0]   msg0_o,
  output logic [DW-1:0]   msg1_o
);
  localparam int PADW = DW - NSRC;

  logic [NSRC-1:0] mask_q, class_q, pend_q, pend_n;
  logic [DW-1:0]   msg0_q, msg1_q, rdata_q, rd_mux;
  logic            pend_clr;

  assign pend_clr = (we_i || re_i) && (addr_i == OFS_PEND[AW-1:0]);

  always_comb begin
    pend_n = pend_q;
    if (pend_clr) pend_n = '0;
    pend_n = pend_n | rise_i;   // new edge wins over a clear
  end

  always_comb begin
    unique case (addr_i)
      OFS_MSG0[AW-1:0]: rd_mux = msg0_q;
      OFS_MSG1[AW-1:0]: rd_mux = msg1_q;
      OFS_REQ0[AW-1:0]: rd_mux = {{PADW{1'b0}}, lvl_i & mask_q & ~class_q};
      OFS_REQ1[AW-1:0]: rd_mux = {{PADW{1'b0}}, lvl_i & mask_q & class_q};
      OFS_MASK[AW-1:0]: rd_mux = {{PADW{1'b0}}, mask_q};
      OFS_PEND[AW-1:0]: rd_mux = {{PADW{1'b0}}, pend_q};
      OFS_CLS[AW-1:0]:  rd_mux = {{PADW{1'b0}}, class_q};
      OFS_LVL[AW-1:0]:  rd_mux = {{PADW{1'b0}}, lvl_i};
      default:          rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q  <= '0;
      class_q <= '0;
      msg0_q  <= '0;
      msg1_q  <= '0;
      pend_q  <= '0;
      rdata_q <= '0;
    end else begin
      pend_q <= pend_n;
      if (re_i) rdata_q <= rd_mux;
      if (we_i) begin
        unique case (addr_i)
          OFS_MSG0[AW-1:0]: msg0_q  <= wdata_i;
          OFS_MSG1[AW-1:0]: msg1_q  <= wdata_i;
          OFS_MASK[AW-1:0]: mask_q  <= wdata_i[NSRC-1:0];
          OFS_CLS[AW-1:0]:  class_q <= wdata_i[NSRC-1:0];
          default: ;
        endcase
      end
    end
  end

  assign rdata_o = rdata_q;
  assign mask_o  = mask_q;
  assign class_o = class_q;
  assign msg0_o  = msg0_q;
  assign msg1_o  = msg1_q;
endmodule

// File: rtl/irq_dispatch.sv
module irq_dispatch #(
  parameter int NSRC = 11,
  parameter int DW   = 32,
  parameter int MLSB = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] arm_i,
  input  logic [NSRC-1:0] class_i,
  input  logic [DW-1:0]   msg0_i,
  input  logic [DW-1:0]   msg1_i,
  output logic            valid_o,
  input  logic            ready_i,
  output logic [DW-1:0]   addr_o,
  output logic [DW-1:0]   data_o
);
  logic [NSRC-1:0] q_q, q_lo, take;
  logic            slot_free, sel_hi;
  logic [DW-1:0]   word, addr_q, data_q;
  logic            valid_q;

  // lowest queued source, one-hot
  assign q_lo      = q_q & (~q_q + {{(NSRC-1){1'b0}}, 1'b1});
  assign slot_free = !valid_q || ready_i;
  assign take      = slot_free ? q_lo : '0;
  assign sel_hi    = |(q_lo & class_i);
  assign word      = sel_hi ? msg1_i : msg0_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_q     <= '0;
      valid_q <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      q_q <= (q_q & ~take) | arm_i;
      if (slot_free) begin
        valid_q <= |q_q;
        if (|q_q) begin
          addr_q <= {word[DW-1:MLSB], {MLSB{1'b0}}};
          data_q <= {{(DW-MLSB){1'b0}}, word[MLSB-1:0]};
        end
      end
    end
  end

  assign valid_o = valid_q;
  assign addr_o  = addr_q;
  assign data_o  = data_q;
endmodule

// File: rtl/irq_msg_ctrl.sv
module irq_msg_ctrl
  import irq_msg_pkg::*;
#(
  parameter int N_SRC  = NSRC,
  parameter int D_W    = DW,
  parameter int A_W    = AW,
  parameter int M_LSB  = MLSB
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_lvl,
  input  logic             reg_we,
  input  logic             reg_re,
  input  logic [A_W-1:0]   reg_addr,
  input  logic [D_W-1:0]   reg_wdata,
  output logic [D_W-1:0]   reg_rdata,
  output logic             msg_valid,
  input  logic             msg_ready,
  output logic [D_W-1:0]   msg_addr,
  output logic [D_W-1:0]   msg_data
);
  logic [N_SRC-1:0] lvl_q, rise, mask, cls;
  logic [D_W-1:0]   msg0, msg1;

  irq_capture #(.NSRC(N_SRC)) u_cap (
    .clk(clk), .rst_n(rst_n), .src_i(src_lvl), .lvl_o(lvl_q), .rise_o(rise)
  );

  irq_regfile #(.NSRC(N_SRC), .DW(D_W), .AW(A_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we_i(reg_we), .re_i(reg_re), .addr_i(reg_addr),
    .wdata_i(reg_wdata), .rdata_o(reg_rdata), .lvl_i(lvl_q), .rise_i(rise),
    .mask_o(mask), .class_o(cls), .msg0_o(msg0), .msg1_o(msg1)
  );

  irq_dispatch #(.NSRC(N_SRC), .DW(D_W), .MLSB(M_LSB)) u_disp (
    .clk(clk), .rst_n(rst_n), .arm_i(rise & mask), .class_i(cls),
    .msg0_i(msg0), .msg1_i(msg1), .valid_o(msg_valid), .ready_i(msg_ready),
    .addr_o(msg_addr), .data_o(msg_data)
  );
endmodule

// File: rtl/irq_msg_ctrl_chk.sv
module irq_msg_ctrl_chk #(
  parameter int N_SRC = 11,
  parameter int D_W   = 32,
  parameter int M_LSB = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_SRC-1:0] src_lvl,
  input logic [N_SRC-1:0] lvl_q,
  input logic             msg_valid,
  input logic             msg_ready,
  input logic [D_W-1:0]   msg_addr,
  input logic [D_W-1:0]   msg_data
);
  AST_LEVEL_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> lvl_q == $past(src_lvl)); // R2
  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_addr) && $stable(msg_data)); // R10
  AST_ADDR_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> msg_addr[M_LSB-1:0] == '0); // R8
  AST_DATA_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> msg_data[D_W-1:M_LSB] == '0); // R8
  AST_IDLE_AFTER_RESET: assert property (@(posedge clk)
    !rst_n |=> !msg_valid); // R1
endmodule

bind irq_msg_ctrl irq_msg_ctrl_chk #(.N_SRC(N_SRC), .D_W(D_W), .M_LSB(M_LSB)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl), .lvl_q(lvl_q),
  .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_addr(msg_addr),
  .msg_data(msg_data)
);

// File: tb/irq_msg_ctrl_tb.sv
module irq_msg_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] src_lvl = '0;
  logic        reg_we = 1'b0, reg_re = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        msg_valid, msg_ready = 1'b0;
  logic [31:0] msg_addr, msg_data;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  irq_msg_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl), .reg_we(reg_we), .reg_re(reg_re),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_addr(msg_addr),
    .msg_data(msg_data)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); reg_re = 1'b1; reg_addr = a;
    @(negedge clk); reg_re = 1'b0; d = reg_rdata;
  endtask

  task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(req, d, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pop(input string req, input logic [31:0] ea, input logic [31:0] ed);
    int w = 0;
    @(negedge clk);
    while (!msg_valid && w < 20) begin @(negedge clk); w++; end
    check({req, " valid"}, {31'd0, msg_valid}, 32'd1);
    check({req, " addr"}, msg_addr, ea);
    check({req, " data"}, msg_data, ed);
    msg_ready = 1'b1;
    @(negedge clk);
    msg_ready = 1'b0;
  endtask

  task automatic t_reset;
    rd_chk("R1 msg0", 12'h004, 0);
    rd_chk("R1 mask", 12'h018, 0);
    rd_chk("R1 pend", 12'h01C, 0);
    rd_chk("R1 class", 12'h024, 0);
    rd_chk("R1 level", 12'h028, 0);
    check("R1 valid", {31'd0, msg_valid}, 0);
    rd_chk("R11 unmapped", 12'h008, 0);
  endtask

  task automatic t_regs;
    wr(12'h004, 32'h1234_5667); rd_chk("R6 msg0", 12'h004, 32'h1234_5667);
    wr(12'h010, 32'hCAFE_F00D); rd_chk("R6 msg1", 12'h010, 32'hCAFE_F00D);
    wr(12'h018, 32'hFFFF_FFFF); rd_chk("R6 mask width", 12'h018, 32'h7FF);
    wr(12'h024, 32'hFFFF_F0F0); rd_chk("R6 class width", 12'h024, 32'h0F0);
    wr(12'h028, 32'h7FF); rd_chk("R2 level write ignored", 12'h028, 0);
    wr(12'h00C, 32'h7FF); rd_chk("R5 req0 write ignored", 12'h00C, 0);
    wr(12'h014, 32'h7FF); rd_chk("R5 req1 write ignored", 12'h014, 0);
    wr(12'h018, 0); wr(12'h024, 0);
  endtask

  task automatic t_pending;
    @(negedge clk); src_lvl = 11'h005;
    idle(2);
    rd_chk("R2 level", 12'h028, 32'h005);
    rd_chk("R3 pend set", 12'h01C, 32'h005);
    rd_chk("R4 cleared by read", 12'h01C, 0);
    idle(3);
    rd_chk("R3 steady high no set", 12'h01C, 0);
    check("R7 masked no message", {31'd0, msg_valid}, 0);
    @(negedge clk); src_lvl = 11'h000;
    idle(2);
    @(negedge clk); src_lvl = 11'h004;
    idle(2);
    wr(12'h01C, 32'h0000_0000);
    rd_chk("R4 write clears", 12'h01C, 0);
    // rise in the same cycle as a clearing read
    @(negedge clk); reg_re = 1'b1; reg_addr = 12'h01C; src_lvl = 11'h005;
    @(negedge clk); reg_re = 1'b0;
    check("R4 read returns old", reg_rdata, 0);
    rd_chk("R4 rise survives clear", 12'h01C, 32'h001);
    @(negedge clk); src_lvl = 11'h000;
    idle(2);
  endtask

  task automatic t_views;
    @(negedge clk); src_lvl = 11'h00F;
    wr(12'h018, 32'h00B); wr(12'h024, 32'h009);
    rd_chk("R5 req0", 12'h00C, 32'h002);
    rd_chk("R5 req1", 12'h014, 32'h009);
    idle(2);
    check("R7 no message without edge", {31'd0, msg_valid}, 0);
    @(negedge clk); src_lvl = 11'h000;
    wr(12'h018, 0); wr(12'h024, 0); wr(12'h01C, 0);
  endtask

  task automatic t_single;
    wr(12'h004, 32'h8000_1043);
    wr(12'h010, 32'h4000_00BF);
    wr(12'h018, 32'h7FF);
    wr(12'h024, 32'h400);
    @(negedge clk); src_lvl = 11'h008;
    pop("R8 class0 via msg0", 32'h8000_1040, 32'h3);
    @(negedge clk); src_lvl = 11'h408;
    pop("R8 class1 via msg1", 32'h4000_00A0, 32'h1F);
    idle(3);
    check("R7 one message per edge", {31'd0, msg_valid}, 0);
    @(negedge clk); src_lvl = 11'h000;
    idle(2);
  endtask

  task automatic t_order;
    wr(12'h024, 32'h080);
    @(negedge clk); src_lvl = 11'h094;   // sources 2, 4, 7
    pop("R9 first src2", 32'h8000_1040, 32'h3);
    pop("R9 second src4", 32'h8000_1040, 32'h3);
    pop("R9 third src7", 32'h4000_00A0, 32'h1F);
    idle(3);
    check("R9 queue empty", {31'd0, msg_valid}, 0);
    @(negedge clk); src_lvl = 11'h000;
    idle(2);
  endtask

  task automatic t_backpressure;
    logic [31:0] a0;
    wr(12'h024, 0);
    @(negedge clk); src_lvl = 11'h020;
    idle(3);
    check("R10 offered", {31'd0, msg_valid}, 1);
    a0 = msg_addr;
    idle(6);
    check("R10 still valid", {31'd0, msg_valid}, 1);
    check("R10 addr held", msg_addr, a0);
    pop("R10 drain", 32'h8000_1040, 32'h3);
    idle(2);
    check("R10 single message", {31'd0, msg_valid}, 0);
    @(negedge clk); src_lvl = 11'h000;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    idle(3);
    @(negedge clk); rst_n = 1'b1;
    t_reset;
    t_regs;
    t_pending;
    t_views;
    t_single;
    t_order;
    t_backpressure;
    idle(2);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule